// File: doc/BRIEF.md
# Dual-Half Timer with Toggle and PWM Outputs

This block is a prescaled timer/counter built from two 8-bit halves. It can run them as two independent timers or chain them into one 16-bit counter. Each half drives one output pin. Depending on the selected mode, that pin is either a toggle output that flips its level on every compare match, or an 8-bit pulse-width signal with a 256-step period. A global clock-enable `tick` paces both prescalers. An optional external event input lets the upper half, or the chained counter, count outside events instead of prescaled ticks.

Software configures the block through a small write-only register port: a control word, one prescaler reload per half and one compare/duty byte per half. Every write to the control word restarts the timer from a clean state. Each half also raises a one-cycle flag when its period completes, and the two flags feed the chip's interrupt logic.

Top module: `pwm_toggle_timer`

## Requirements
- R1: Writing `wr_addr`=0 loads the control word from `wr_data[3:0]`: bits 1:0 are the mode (0 split toggle, 1 dual PWM, 2 wide toggle, 3 wide PWM), bit 2 selects external counting and bit 3 is run. The same write clears both counters, both prescalers, both toggle levels and both flags. After reset, and while run is 0, both outputs and both flags are low and the counters stay at zero.
- R2: A half's prescaler, reloaded through address 1 (lower) or address 2 (upper) with value P, advances that half's count once every P+1 cycles in which `tick` is high. With `tick` low and no external events, no output or flag changes.
- R3: In mode 0, each half counts from 0 up to its compare byte (address 3 lower, address 4 upper), then restarts at 0. At that restart it inverts its toggle output and pulses its flag, so the output toggles every compare+1 steps.
- R4: In mode 0 with control bit 2 set, the upper half counts single-cycle pulses on `ext_cnt` instead of its prescaler steps.
- R5: In modes 1 and 3, a PWM output is high for the first D steps of each 256-step period, where D is the duty byte. A duty of 0 keeps the output low. In mode 1 the two halves run as separate PWM channels with their own prescalers, and each half's flag pulses at the end of its period.
- R6: Duty bytes are double-buffered. A new duty value written in the middle of a period takes effect at the start of the next period, or at a control write.
- R7: In mode 2, the 16-bit count {upper, lower} advances on lower prescaler steps, or on `ext_cnt` pulses when bit 2 is set. When it equals {address 4, address 3} it restarts at 0, toggles `out_hi` and pulses `irq_hi`.
- R8: In mode 2, `out_lo` toggles and `irq_lo` pulses each time the lower byte carries from 255 into the upper byte.
- R9: In mode 3, the lower byte is a PWM with duty from address 3. The upper byte counts PWM periods, and after period number (address 4)+1 the counter restarts, `out_hi` toggles and `irq_hi` pulses. `irq_lo` pulses at the end of every PWM period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Clock enable for both prescalers |
| ext_cnt | input | 1 | External count event, single-cycle synchronous pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1/2 prescalers, 3/4 compare or duty) |
| wr_data | input | 8 | Register write data |
| out_lo | output | 1 | Lower-half toggle or PWM output |
| out_hi | output | 1 | Upper-half toggle or PWM output |
| irq_lo | output | 1 | Lower-half period flag, one cycle |
| irq_hi | output | 1 | Upper-half or 16-bit period flag, one cycle |

## Verification
Every result is registered. A step taken at a clock edge shows on the outputs and flags from that edge on, and the bench samples on falling edges, so each sample reflects all inputs driven before the previous rising edge. Periods and duty ratios are measured over windows that are whole multiples of the expected period. Transitions, high samples and flag pulses in such a window come out exact whatever the phase at which the window starts. The one phase-sensitive check, double buffering, counts falling edges from the restarting control write and samples 150 steps into the current period and 150 steps into the next, well away from both duty edges.

// File: rtl/tmr_pkg.sv
// Shared types and register addresses for the dual-half timer.
// Assumes a 3-bit register address and an 8-bit write data path.
package tmr_pkg;

    localparam int TMR_ADDR_W = 3;
    localparam int TMR_DATA_W = 8;

    localparam logic [TMR_ADDR_W-1:0] ADDR_CTRL   = 3'd0;
    localparam logic [TMR_ADDR_W-1:0] ADDR_PRE_LO = 3'd1;
    localparam logic [TMR_ADDR_W-1:0] ADDR_PRE_HI = 3'd2;
    localparam logic [TMR_ADDR_W-1:0] ADDR_CMP_LO = 3'd3;
    localparam logic [TMR_ADDR_W-1:0] ADDR_CMP_HI = 3'd4;

    typedef enum logic [1:0] {
        MODE_SPLIT_TOG = 2'd0,
        MODE_DUAL_PWM  = 2'd1,
        MODE_WIDE_TOG  = 2'd2,
        MODE_WIDE_PWM  = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic      run;
        logic      hi_ext;
        tmr_mode_e mode;
    } tmr_ctrl_t;

endpackage

// File: rtl/tmr_prescaler.sv
// Reloadable prescaler: emits a one-cycle step every RELOAD+1 enabled cycles.
// Assumes clr has priority and that the step is used in the same cycle.
module tmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [PRE_W-1:0] reload,
    output logic             step
);

    logic [PRE_W-1:0] div_q;

    // Step fires on the enabled cycle in which the divider hits its reload.
    assign step = en && (div_q == reload);

    // Divider counts enabled cycles and restarts after each step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            div_q <= '0;
        end else if (step) begin
            div_q <= '0;
        end else if (en) begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_byte_cnt.sv
// One half of the timer count: increments on inc, returns to zero on clr.
// Assumes wrap past all-ones is the natural modulo behaviour.
module tmr_byte_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    // Count register with clear taking priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_pwm_gen.sv
// PWM level generator for one 2**CNT_W-step period with a buffered duty.
// Assumes cnt is the half's count before the advance, and that the count
// wraps from all-ones to zero, which marks the start of a period.
module tmr_pwm_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             adv,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty_in,
    output logic             pwm,
    output logic [CNT_W-1:0] duty_act
);

    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    logic [CNT_W-1:0] cnt_nxt;
    logic             period_start;

    assign cnt_nxt      = cnt + 1'b1;
    assign period_start = adv && (cnt == CNT_LAST);

    // Active duty is loaded only at a period boundary or restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_act <= '0;
        end else if (restart || period_start) begin
            duty_act <= duty_in;
        end
    end

    // Level rises at period start (non-zero duty) and falls at the duty count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm <= 1'b0;
        end else if (restart || period_start) begin
            pwm <= (duty_in != '0);
        end else if (adv && (cnt_nxt == duty_act)) begin
            pwm <= 1'b0;
        end
    end

endmodule

// File: rtl/pwm_toggle_timer.sv
// Dual-half timer/counter with toggle and PWM outputs in four modes.
// Assumes ext_cnt is a synchronous single-cycle pulse and that software
// writes the control word to (re)start the timer after setting values.
module pwm_toggle_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  ext_cnt,
    input  logic                  wr_en,
    input  logic [TMR_ADDR_W-1:0] wr_addr,
    input  logic [TMR_DATA_W-1:0] wr_data,
    output logic                  out_lo,
    output logic                  out_hi,
    output logic                  irq_lo,
    output logic                  irq_hi
);

    localparam int               HALVES   = 2;
    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    tmr_ctrl_t              ctrl_q;
    logic [PRE_W-1:0]       pre_q   [HALVES];
    logic [CNT_W-1:0]       cmp_q   [HALVES];
    logic [CNT_W-1:0]       cnt     [HALVES];
    logic [CNT_W-1:0]       duty_act[HALVES];
    logic [HALVES-1:0]      step, ev, clr_cnt, flip, irq_set, pwm_lvl;
    logic [HALVES-1:0]      tog_q, irq_q;
    logic                   restart, run, ext_ev, carry, wide_hit;
    logic [1:0]             mode_w;

    assign restart = wr_en && (wr_addr == ADDR_CTRL);
    assign run     = ctrl_q.run;
    assign ext_ev  = ext_cnt && run;
    assign mode_w  = ctrl_q.mode;

    // Register file: control word, prescaler reloads and compare/duty bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            for (int i = 0; i < HALVES; i++) begin
                pre_q[i] <= '0;
                cmp_q[i] <= '0;
            end
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL:   ctrl_q   <= tmr_ctrl_t'(wr_data[3:0]);
                ADDR_PRE_LO: pre_q[0] <= wr_data[PRE_W-1:0];
                ADDR_PRE_HI: pre_q[1] <= wr_data[PRE_W-1:0];
                ADDR_CMP_LO: cmp_q[0] <= wr_data[CNT_W-1:0];
                ADDR_CMP_HI: cmp_q[1] <= wr_data[CNT_W-1:0];
                default:     ;
            endcase
        end
    end

    // Per-half prescaler, counter and PWM level generator.
    for (genvar g = 0; g < HALVES; g++) begin : g_half
        tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (restart),
            .en     (tick && run),
            .reload (pre_q[g]),
            .step   (step[g])
        );

        tmr_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (restart || clr_cnt[g]),
            .inc   (ev[g]),
            .cnt   (cnt[g])
        );

        tmr_pwm_gen #(.CNT_W(CNT_W)) u_pwm (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (restart),
            .adv      (ev[g]),
            .cnt      (cnt[g]),
            .duty_in  (cmp_q[g]),
            .pwm      (pwm_lvl[g]),
            .duty_act (duty_act[g])
        );
    end

    // Mode decode: count sources, restarts, toggles and period flags.
    always_comb begin
        ev       = '0;
        clr_cnt  = '0;
        flip     = '0;
        irq_set  = '0;
        carry    = 1'b0;
        wide_hit = 1'b0;
        case (ctrl_q.mode)
            MODE_SPLIT_TOG: begin
                ev[0] = step[0];
                ev[1] = ctrl_q.hi_ext ? ext_ev : step[1];
                for (int i = 0; i < HALVES; i++) begin
                    clr_cnt[i] = ev[i] && (cnt[i] == cmp_q[i]);
                    flip[i]    = clr_cnt[i];
                    irq_set[i] = clr_cnt[i];
                end
            end
            MODE_DUAL_PWM: begin
                ev = step;
                for (int i = 0; i < HALVES; i++) begin
                    irq_set[i] = ev[i] && (cnt[i] == CNT_LAST);
                end
            end
            MODE_WIDE_TOG: begin
                ev[0]    = ctrl_q.hi_ext ? ext_ev : step[0];
                carry    = ev[0] && (cnt[0] == CNT_LAST);
                wide_hit = ev[0] && (cnt[0] == cmp_q[0]) && (cnt[1] == cmp_q[1]);
                ev[1]    = carry;
                clr_cnt  = {wide_hit, wide_hit};
                flip[1]  = wide_hit;
                irq_set[1] = wide_hit;
                flip[0]    = carry && !wide_hit;
                irq_set[0] = carry && !wide_hit;
            end
            default: begin
                ev[0]      = step[0];
                carry      = ev[0] && (cnt[0] == CNT_LAST);
                wide_hit   = carry && (cnt[1] == cmp_q[1]);
                ev[1]      = carry;
                clr_cnt[1] = wide_hit;
                flip[1]    = wide_hit;
                irq_set[1] = wide_hit;
                irq_set[0] = carry;
            end
        endcase
    end

    // Toggle levels and period flags, both cleared by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tog_q <= '0;
            irq_q <= '0;
        end else begin
            tog_q <= tog_q ^ flip;
            irq_q <= irq_set;
        end
    end

    assign out_lo = run && (((ctrl_q.mode == MODE_DUAL_PWM) || (ctrl_q.mode == MODE_WIDE_PWM))
                            ? pwm_lvl[0] : tog_q[0]);
    assign out_hi = run && ((ctrl_q.mode == MODE_DUAL_PWM) ? pwm_lvl[1] : tog_q[1]);
    assign irq_lo = irq_q[0];
    assign irq_hi = irq_q[1];

endmodule

// File: rtl/pwm_toggle_timer_chk.sv
// Property checker for the dual-half timer, bound to the top module.
// Assumes it sees the registered control fields and the half counts.
module pwm_toggle_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             ext_cnt,
    input logic             wr_en,
    input logic             run,
    input logic [1:0]       mode,
    input logic             out_lo,
    input logic             out_hi,
    input logic             irq_lo,
    input logic             irq_hi,
    input logic [CNT_W-1:0] cnt_lo,
    input logic [CNT_W-1:0] cnt_hi,
    input logic [CNT_W-1:0] duty_lo,
    input logic [CNT_W-1:0] duty_hi
);

    // R1
    stopped_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (cnt_lo == '0) && (cnt_hi == '0) && !irq_lo && !irq_hi);

    // R2
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ext_cnt && !wr_en) |=> $stable(out_lo) && $stable(out_hi) && !irq_lo && !irq_hi);

    // R3
    split_flag_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lo && mode == 2'd0) |-> (out_lo != $past(out_lo)));

    // R5
    zero_duty_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (mode == 2'd1 || mode == 2'd3) && duty_lo == '0) |-> !out_lo);

    // R5
    zero_duty_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == 2'd1 && duty_hi == '0) |-> !out_hi);

    // R7
    wide_tog_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi && mode == 2'd2) |-> (cnt_lo == '0) && (cnt_hi == '0));

    // R9
    wide_pwm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi && mode == 2'd3) |-> (cnt_lo == '0) && (cnt_hi == '0));

endmodule

bind pwm_toggle_timer pwm_toggle_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .ext_cnt (ext_cnt),
    .wr_en   (wr_en),
    .run     (run),
    .mode    (mode_w),
    .out_lo  (out_lo),
    .out_hi  (out_hi),
    .irq_lo  (irq_lo),
    .irq_hi  (irq_hi),
    .cnt_lo  (cnt[0]),
    .cnt_hi  (cnt[1]),
    .duty_lo (duty_act[0]),
    .duty_hi (duty_act[1])
);

// File: tb/pwm_toggle_timer_tb.sv
`timescale 1ns/1ps
module pwm_toggle_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       ext_cnt = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       out_lo, out_hi, irq_lo, irq_hi;

    int checks = 0;
    int failures = 0;
    int hi_lo, hi_hi, tr_lo, tr_hi, ir_lo, ir_hi;

    always #5 clk = ~clk;

    pwm_toggle_timer u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ext_cnt (ext_cnt),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .out_lo  (out_lo),
        .out_hi  (out_hi),
        .irq_lo  (irq_lo),
        .irq_hi  (irq_hi)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Register write; called and returns on a falling edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Observe n falling-edge samples: highs, transitions and flag pulses.
    task automatic measure(input int n);
        logic pl, ph;
        hi_lo = 0; hi_hi = 0; tr_lo = 0; tr_hi = 0; ir_lo = 0; ir_hi = 0;
        pl = out_lo; ph = out_hi;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hi_lo += int'(out_lo); hi_hi += int'(out_hi);
            tr_lo += int'(out_lo != pl); tr_hi += int'(out_hi != ph);
            ir_lo += int'(irq_lo); ir_hi += int'(irq_hi);
            pl = out_lo; ph = out_hi;
        end
    endtask

    task automatic t_reset();
        check("R1 reset out_lo", int'(out_lo), 0);
        check("R1 reset out_hi", int'(out_hi), 0);
        check("R1 reset irq", int'(irq_lo | irq_hi), 0);
    endtask

    task automatic t_run_off();
        wr(3'd3, 8'd2); wr(3'd4, 8'd2); wr(3'd0, 8'h00);
        measure(100);
        check("R1 stopped transitions", tr_lo + tr_hi, 0);
        check("R1 stopped highs", hi_lo + hi_hi, 0);
        check("R1 stopped flags", ir_lo + ir_hi, 0);
    endtask

    task automatic t_split();
        wr(3'd1, 8'd0); wr(3'd2, 8'd0); wr(3'd3, 8'd9); wr(3'd4, 8'd4);
        wr(3'd0, 8'h08);
        measure(100);
        check("R3 lo toggles", tr_lo, 10);
        check("R3 lo flags", ir_lo, 10);
        check("R3 hi toggles", tr_hi, 20);
    endtask

    task automatic t_prescale();
        wr(3'd1, 8'd3); wr(3'd3, 8'd4); wr(3'd0, 8'h08);
        measure(200);
        check("R2 prescaled toggles", tr_lo, 10);
        tick = 1'b0;
        measure(100);
        check("R2 no tick toggles", tr_lo + tr_hi, 0);
        check("R2 no tick flags", ir_lo + ir_hi, 0);
        tick = 1'b1;
        wr(3'd1, 8'd0);
    endtask

    task automatic t_ext();
        int tr;
        logic ph;
        wr(3'd2, 8'd0); wr(3'd4, 8'd2); wr(3'd0, 8'h0C);
        tr = 0; ph = out_hi;
        for (int i = 0; i < 9; i++) begin
            ext_cnt = 1'b1;
            @(negedge clk);
            tr += int'(out_hi != ph); ph = out_hi;
            ext_cnt = 1'b0;
            repeat (2) begin
                @(negedge clk);
                tr += int'(out_hi != ph); ph = out_hi;
            end
        end
        check("R4 external toggles", tr, 3);
        check("R4 external level", int'(out_hi), 1);
    endtask

    task automatic t_pwm();
        wr(3'd1, 8'd0); wr(3'd2, 8'd1); wr(3'd3, 8'd64); wr(3'd4, 8'd192);
        wr(3'd0, 8'h09);
        measure(512);
        check("R5 lo duty 64", hi_lo, 128);
        check("R5 hi duty 192 prescaled", hi_hi, 384);
        check("R5 lo period flags", ir_lo, 2);
        wr(3'd2, 8'd0); wr(3'd3, 8'd0); wr(3'd4, 8'd255);
        wr(3'd0, 8'h09);
        measure(512);
        check("R5 duty zero low", hi_lo, 0);
        check("R5 duty 255", hi_hi, 510);
    endtask

    task automatic t_buffer();
        wr(3'd3, 8'd100); wr(3'd0, 8'h09);
        repeat (10) @(negedge clk);
        wr(3'd3, 8'd200);
        repeat (139) @(negedge clk);
        check("R6 old duty holds in period", int'(out_lo), 0);
        repeat (256) @(negedge clk);
        check("R6 new duty next period", int'(out_lo), 1);
    endtask

    task automatic t_wide_tog();
        wr(3'd3, 8'h01); wr(3'd4, 8'h02); wr(3'd0, 8'h0A);
        measure(1028);
        check("R7 wide toggles", tr_hi, 2);
        check("R7 wide flags", ir_hi, 2);
        check("R8 carry toggles", tr_lo, 4);
        check("R8 carry flags", ir_lo, 4);
    endtask

    task automatic t_wide_pwm();
        wr(3'd3, 8'd64); wr(3'd4, 8'd2); wr(3'd0, 8'h0B);
        measure(1536);
        check("R9 wide toggles", tr_hi, 2);
        check("R9 wide flags", ir_hi, 2);
        check("R9 lo pwm highs", hi_lo, 384);
        check("R9 lo period flags", ir_lo, 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run_off();
        t_split();
        t_prescale();
        t_ext();
        t_pwm();
        t_buffer();
        t_wide_tog();
        t_wide_pwm();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule